// File: doc/BRIEF.md
# Ignition Driver Protection Sequencer

This block is the digital control sequencer of a smart ignition switch driver. It takes the command input and an active-low enable input, removes short glitches from both by clock count, and turns the power-switch gate on at a filtered command rising edge. A filtered command falling edge turns the gate off abruptly, which produces the spark. A set of protection inputs can interrupt a charge that is in progress: an over-temperature comparator, an input overvoltage comparator, a supply overvoltage comparator, a bond-wire fault bit, and loss of enable. In that case the block drops the gate and raises a low-voltage-clamp enable instead. This soft shutdown drains the coil without a spark.

A soft shutdown lasts until the coil-current-zero indicator asserts, or until the command falls, whichever comes first. On a command fall the clamp is released at once so that the remaining energy ends in a normal turn-off. Each fault class has its own restart rule. Input overvoltage is treated in real time: the charge resumes once the condition clears. Over-temperature, supply overvoltage, bond-wire fault and loss of enable are held until a fresh command rising edge. A supply overvoltage only counts once it has persisted for a programmable number of clock samples.

Top module: `ign_prot_seq`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `gate_on` and `clamp_en` are 0. The enable filter output starts in the disabled state.
- R2: A change on `cmd_raw` or `en_n_raw` takes effect only after the new level has been seen on FILT_CYCLES consecutive clock edges. A command rise then shows on `gate_on` at edge FILT_CYCLES+1. A pulse shorter than FILT_CYCLES edges has no effect.
- R3: With enable active (`en_n_raw` = 0) and no fault present, a command rise sets `gate_on` = 1 and a command fall clears it, with `clamp_en` staying 0 throughout.
- R4: While `gate_on` = 1, any of the following moves the block to soft shutdown (`gate_on` = 0, `clamp_en` = 1) on the next edge at which the fault is seen: `therm_hot` = 1, `bond_fault` = 1, `inp_ov` = 1, a confirmed supply overvoltage, or a filtered `en_n_raw` = 1.
- R5: A soft shutdown keeps `clamp_en` = 1 until `coil_zero` = 1 is sampled. The edge after that clears both outputs.
- R6: A filtered command fall during a soft shutdown clears `clamp_en` on the next edge, whatever faults are still present.
- R7: After a shutdown caused by loss of enable, bringing enable back while the command is high does not turn the gate on. Turning the gate on again requires enable active and then a new command rising edge.
- R8: Input overvoltage is real time. If it is the only fault and it clears while the command is still high, `gate_on` returns to 1 on the next edge. This also applies when a command rise arrived while the overvoltage was present.
- R9: A supply overvoltage is confirmed only after `sup_ov` = 1 on SUPOV_CYCLES consecutive edges. A shorter episode has no effect. After a confirmed trip, the gate stays off until `sup_ov` is 0 and a new command rising edge arrives.
- R10: A command rise while `therm_hot` = 1 is ignored. After a thermal shutdown, cooling alone does not turn the gate on; a new command rising edge is needed.
- R11: `gate_on` and `clamp_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (nominally 2 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_raw | input | 1 | Ignition command, 1 = charge coil |
| en_n_raw | input | 1 | Enable, 0 = active, 1 = disabled |
| therm_hot | input | 1 | Over-temperature comparator with hysteresis, 1 = too hot |
| inp_ov | input | 1 | Command-pin overvoltage comparator, 1 = overvoltage |
| sup_ov | input | 1 | Supply overvoltage comparator with hysteresis, 1 = overvoltage |
| bond_fault | input | 1 | Bond-wire disconnection detected |
| coil_zero | input | 1 | Coil current has reached zero |
| gate_on | output | 1 | Power-switch gate request |
| clamp_en | output | 1 | Low-voltage clamp (soft shutdown) enable |

## Verification
The checker assumes that all inputs are synchronous to `clk` and change only between edges. It also assumes that the comparator inputs are already free of glitches, so only the command and enable paths need the filter. Its properties relate gate and clamp changes to the filtered command and enable levels and to the raw fault levels seen at the edge before. The stimulus drives every input on the falling clock edge and holds each fault level for at least one full cycle. It sweeps glitch lengths below the filter window and supply-overvoltage durations on both sides of the persistence limit. Each fault class is exercised in turn through trip, discharge and restart.

// File: rtl/ign_prot_pkg.sv
package ign_prot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ON    = 2'd1,
    ST_SSD   = 2'd2,
    ST_REARM = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ign_prot_deglitch.sv
// Count-based glitch filter: output follows input only after the new level
// has been sampled on CYCLES consecutive edges.
module ign_prot_deglitch #(
  parameter int   CYCLES  = 32,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dout <= RST_VAL;
    end else if (din != dout) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        dout <= din;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/ign_prot_persist.sv
// Persistence timer: confirms a level after CYCLES consecutive high samples,
// drops the confirmation as soon as the level goes low.
module ign_prot_persist #(
  parameter int CYCLES = 440
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic confirmed
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !level) begin
      cnt       <= '0;
      confirmed <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      if (cnt == LAST)  confirmed <= 1'b1;
    end
  end
endmodule

// File: rtl/ign_prot_fsm.sv
// Charge / soft-shutdown / re-arm sequencer with registered outputs.
module ign_prot_fsm
  import ign_prot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_lvl,
  input  logic en_act,
  input  logic therm_hot,
  input  logic inp_ov,
  input  logic sup_trip,
  input  logic bond_fault,
  input  logic coil_zero,
  output logic gate_on,
  output logic clamp_en
);
  seq_state_t state, nxt;
  logic cmd_prev;
  logic hold, hold_nxt;       // a latched-class fault was seen in this episode
  logic cmd_rise, cmd_fall;
  logic latched_f, rt_f, clean;

  assign cmd_rise  = cmd_lvl & ~cmd_prev;
  assign cmd_fall  = ~cmd_lvl & cmd_prev;
  assign latched_f = therm_hot | bond_fault | sup_trip | ~en_act;
  assign rt_f      = inp_ov;
  assign clean     = ~hold & ~latched_f & ~rt_f;

  always_comb begin
    nxt      = state;
    hold_nxt = hold;
    unique case (state)
      ST_IDLE: begin
        hold_nxt = 1'b0;
        if (cmd_rise && !latched_f) nxt = rt_f ? ST_REARM : ST_ON;
      end
      ST_ON: begin
        if (cmd_fall) begin
          nxt = ST_IDLE;
        end else if (latched_f || rt_f) begin
          nxt      = ST_SSD;
          hold_nxt = latched_f;
        end
      end
      ST_SSD: begin
        hold_nxt = hold | latched_f;
        if (cmd_fall)       nxt = ST_IDLE;
        else if (coil_zero) nxt = ST_REARM;
        else if (clean)     nxt = ST_ON;
      end
      ST_REARM: begin
        hold_nxt = hold | latched_f;
        if (!cmd_lvl)   nxt = ST_IDLE;
        else if (clean) nxt = ST_ON;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_prev <= 1'b0;
      hold     <= 1'b0;
      gate_on  <= 1'b0;
      clamp_en <= 1'b0;
    end else begin
      state    <= nxt;
      cmd_prev <= cmd_lvl;
      hold     <= hold_nxt;
      gate_on  <= (nxt == ST_ON);
      clamp_en <= (nxt == ST_SSD);
    end
  end
endmodule

// File: rtl/ign_prot_seq.sv
module ign_prot_seq #(
  parameter int FILT_CYCLES  = 32,
  parameter int SUPOV_CYCLES = 440
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_raw,
  input  logic en_n_raw,
  input  logic therm_hot,
  input  logic inp_ov,
  input  logic sup_ov,
  input  logic bond_fault,
  input  logic coil_zero,
  output logic gate_on,
  output logic clamp_en
);
  localparam int NFILT = 2;
  localparam logic [NFILT-1:0] FILT_RST = 2'b10; // bit1 = enable (disabled)

  logic [NFILT-1:0] raw_vec, flt_vec;
  logic cmd_flt, en_n_flt, sup_trip;

  assign raw_vec = {en_n_raw, cmd_raw};

  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    ign_prot_deglitch #(
      .CYCLES (FILT_CYCLES),
      .RST_VAL(FILT_RST[i])
    ) u_flt (
      .clk (clk),
      .rst (rst),
      .din (raw_vec[i]),
      .dout(flt_vec[i])
    );
  end

  assign cmd_flt  = flt_vec[0];
  assign en_n_flt = flt_vec[1];

  ign_prot_persist #(.CYCLES(SUPOV_CYCLES)) u_supov (
    .clk      (clk),
    .rst      (rst),
    .level    (sup_ov),
    .confirmed(sup_trip)
  );

  ign_prot_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_lvl   (cmd_flt),
    .en_act    (~en_n_flt),
    .therm_hot (therm_hot),
    .inp_ov    (inp_ov),
    .sup_trip  (sup_trip),
    .bond_fault(bond_fault),
    .coil_zero (coil_zero),
    .gate_on   (gate_on),
    .clamp_en  (clamp_en)
  );
endmodule

// File: rtl/ign_prot_seq_chk.sv
module ign_prot_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_flt,
  input logic en_n_flt,
  input logic therm_hot,
  input logic inp_ov,
  input logic bond_fault,
  input logic coil_zero,
  input logic gate_on,
  input logic clamp_en
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!gate_on && !clamp_en));

  assert_turn_on_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> ($past(cmd_flt) && !$past(en_n_flt)));

  assert_fault_drops_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (gate_on && (therm_hot || bond_fault || inp_ov)) |=> !gate_on);

  assert_clamp_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(clamp_en) && !gate_on) |-> ($past(coil_zero) || !$past(cmd_flt)));

  assert_ov_blocks_on_R8: assert property (@(posedge clk) disable iff (rst)
    (!gate_on && inp_ov) |=> !gate_on);

  assert_hot_blocks_on_R10: assert property (@(posedge clk) disable iff (rst)
    (!gate_on && therm_hot) |=> !gate_on);

  assert_gate_clamp_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(gate_on && clamp_en));
endmodule

bind ign_prot_seq ign_prot_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_flt   (cmd_flt),
  .en_n_flt  (en_n_flt),
  .therm_hot (therm_hot),
  .inp_ov    (inp_ov),
  .bond_fault(bond_fault),
  .coil_zero (coil_zero),
  .gate_on   (gate_on),
  .clamp_en  (clamp_en)
);

// File: tb/ign_prot_seq_tb.sv
module ign_prot_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int SUP  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_raw = 1'b0, en_n_raw = 1'b0, therm_hot = 1'b0, inp_ov = 1'b0;
  logic sup_ov = 1'b0, bond_fault = 1'b0, coil_zero = 1'b0;
  logic gate_on, clamp_en;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ign_prot_seq #(.FILT_CYCLES(FILT), .SUPOV_CYCLES(SUP)) u_dut (
    .clk(clk), .rst(rst), .cmd_raw(cmd_raw), .en_n_raw(en_n_raw),
    .therm_hot(therm_hot), .inp_ov(inp_ov), .sup_ov(sup_ov),
    .bond_fault(bond_fault), .coil_zero(coil_zero),
    .gate_on(gate_on), .clamp_en(clamp_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic g_exp, input logic c_exp);
    checks++;
    if (gate_on !== g_exp || clamp_en !== c_exp) begin
      errors++;
      $display("FAIL %s: gate=%0b clamp=%0b expected gate=%0b clamp=%0b",
               req, gate_on, clamp_en, g_exp, c_exp);
    end
    checks++;
    if (gate_on === 1'b1 && clamp_en === 1'b1) begin
      errors++;
      $display("FAIL R11 (%s): gate=1 clamp=1 expected not both", req);
    end
  endtask

  task automatic set_cmd(input logic v);
    cmd_raw = v;
    tick(FILT + 1);
  endtask

  task automatic set_fault(input int idx, input logic v);
    case (idx)
      0: therm_hot  = v;
      1: bond_fault = v;
      2: inp_ov     = v;
      3: sup_ov     = v;
      default: en_n_raw = v;
    endcase
  endtask

  function automatic int trip_delay(input int idx);
    if (idx == 3) return SUP + 1;
    if (idx == 4) return FILT + 1;
    return 1;
  endfunction

  // discharge and return to idle with command low
  task automatic drain_to_idle();
    coil_zero = 1'b1; tick(1); coil_zero = 1'b0;
    set_cmd(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(3);
    chk("R1 in reset", 1'b0, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1 after reset", 1'b0, 1'b0);
    tick(FILT + 2);

    // R2: glitches shorter than the window are dropped
    for (int len = 1; len < FILT; len++) begin
      cmd_raw = 1'b1; tick(len); cmd_raw = 1'b0; tick(FILT + 1);
      chk($sformatf("R2 glitch len %0d", len), 1'b0, 1'b0);
    end
    // R2 / R3: exact latency of turn-on and turn-off
    cmd_raw = 1'b1; tick(FILT);
    chk("R2 before latency", 1'b0, 1'b0);
    tick(1);
    chk("R3 gate on", 1'b1, 1'b0);
    cmd_raw = 1'b0; tick(FILT);
    chk("R2 off before latency", 1'b1, 1'b0);
    tick(1);
    chk("R3 gate off", 1'b0, 1'b0);

    // R4/R5 and restart rules per fault class
    for (int f = 0; f < 5; f++) begin
      set_cmd(1'b1);
      chk($sformatf("R3 on before fault %0d", f), 1'b1, 1'b0);
      set_fault(f, 1'b1);
      if (trip_delay(f) > 1) begin
        tick(trip_delay(f) - 1);
        chk($sformatf("R4 before trip fault %0d", f), 1'b1, 1'b0);
        tick(1);
      end else begin
        tick(1);
      end
      chk($sformatf("R4 trip fault %0d", f), 1'b0, 1'b1);
      tick(3);
      chk($sformatf("R5 clamp held fault %0d", f), 1'b0, 1'b1);
      coil_zero = 1'b1; tick(1); coil_zero = 1'b0;
      chk($sformatf("R5 released fault %0d", f), 1'b0, 1'b0);
      set_fault(f, 1'b0);
      tick(FILT + 2);
      if (f == 2) chk("R8 resume after ov clears", 1'b1, 1'b0);
      else if (f == 4) chk("R7 enable back, no edge", 1'b0, 1'b0);
      else if (f == 3) chk("R9 sup cleared, no edge", 1'b0, 1'b0);
      else if (f == 0) chk("R10 cooled, no edge", 1'b0, 1'b0);
      else chk("R4 bond cleared, no edge", 1'b0, 1'b0);
      set_cmd(1'b0);
      set_cmd(1'b1);
      chk($sformatf("R7 restart on new edge fault %0d", f), 1'b1, 1'b0);
      set_cmd(1'b0);
    end

    // R6: command fall during soft shutdown releases clamp
    set_cmd(1'b1);
    therm_hot = 1'b1; tick(1);
    chk("R6 in shutdown", 1'b0, 1'b1);
    cmd_raw = 1'b0; tick(FILT);
    chk("R6 before filtered fall", 1'b0, 1'b1);
    tick(1);
    chk("R6 clamp released on fall", 1'b0, 1'b0);
    therm_hot = 1'b0; tick(2);

    // R8: real-time overvoltage inside shutdown, and blocked rise
    set_cmd(1'b1);
    inp_ov = 1'b1; tick(1);
    chk("R8 ov shutdown", 1'b0, 1'b1);
    inp_ov = 1'b0; tick(1);
    chk("R8 resume in shutdown", 1'b1, 1'b0);
    set_cmd(1'b0);
    inp_ov = 1'b1;
    set_cmd(1'b1);
    chk("R8 rise blocked by ov", 1'b0, 1'b0);
    inp_ov = 1'b0; tick(1);
    chk("R8 on when ov clears", 1'b1, 1'b0);
    set_cmd(1'b0);

    // R10: rise while hot is ignored
    therm_hot = 1'b1;
    set_cmd(1'b1);
    chk("R10 rise while hot", 1'b0, 1'b0);
    therm_hot = 1'b0; tick(3);
    chk("R10 cooled, command high", 1'b0, 1'b0);
    set_cmd(1'b0);
    set_cmd(1'b1);
    chk("R10 new edge after cooling", 1'b1, 1'b0);
    set_cmd(1'b0);

    // R9: sweep supply-overvoltage duration around the limit
    for (int len = 1; len <= SUP + 2; len++) begin
      set_cmd(1'b1);
      sup_ov = 1'b1; tick(len); sup_ov = 1'b0; tick(1);
      if (len >= SUP) begin
        chk($sformatf("R9 trip len %0d", len), 1'b0, 1'b1);
        drain_to_idle();
      end else begin
        chk($sformatf("R9 no trip len %0d", len), 1'b1, 1'b0);
        set_cmd(1'b0);
      end
    end
    // R9: restart blocked while supply overvoltage remains
    set_cmd(1'b1);
    sup_ov = 1'b1; tick(SUP + 1);
    chk("R9 long ov trips", 1'b0, 1'b1);
    drain_to_idle();
    set_cmd(1'b1);
    chk("R9 rise blocked while ov", 1'b0, 1'b0);
    sup_ov = 1'b0; tick(2);
    chk("R9 ov gone, no edge", 1'b0, 1'b0);
    set_cmd(1'b0);
    set_cmd(1'b1);
    chk("R9 new edge restarts", 1'b1, 1'b0);

    // R7: rise while enable inactive is ignored
    set_cmd(1'b0);
    en_n_raw = 1'b1; tick(FILT + 1);
    set_cmd(1'b1);
    chk("R7 rise while disabled", 1'b0, 1'b0);
    en_n_raw = 1'b0; tick(FILT + 2);
    chk("R7 enabled, no edge", 1'b0, 1'b0);
    set_cmd(1'b0);
    set_cmd(1'b1);
    chk("R7 edge after enable", 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule